// File: doc/BRIEF.md
# Program and Data Address Generator

This block holds both address registers of a small 8-bit accumulator processor. One is the program counter, which sequences instruction fetch. The other is the data address register, which drives the data memory port. The sequencer gives the block one control word per cycle: a PC operation code, a PC load enable, an interrupt-take strobe and the condition flag for the PC, and a load enable and a source select for the data address. It also passes in the 12-bit address field of the current instruction, the register-bus byte and the base-pointer byte.

The program counter can step, jump, jump on a condition, call, return, take an interrupt vector, and return from an interrupt. Subroutine and interrupt each keep exactly one saved address, in their own link registers, so nesting is not possible. The data address register is loaded either with the instruction's address field or with an indexed address. The indexed address shifts the base pointer left by four bits and adds the index byte, which lets an 8-bit data path reach 4096 data words.

Top module: `agu_top`

## Requirements
- R1: While rst_n is low, and at the first edge after release, prog_addr and data_addr read 0x000. Both saved return addresses are also 0x000, so a return or an interrupt return issued first after reset goes to 0x000.
- R2: On a cycle with pc_we low, prog_addr keeps its value whatever pc_op, irq_take, flag and addr_field carry. Neither saved return address changes on such a cycle.
- R3: With pc_we high and irq_take low, pc_op 0 (step) and pc_op 7 (reserved) both load prog_addr+1. The increment wraps from 0xFFF to 0x000.
- R4: pc_op 1 (jump) loads prog_addr with addr_field.
- R5: pc_op 2 loads addr_field when flag is 1 and otherwise steps. pc_op 3 loads addr_field when flag is 0 and otherwise steps.
- R6: pc_op 4 (call) loads addr_field and saves prog_addr+1, modulo 4096, as the subroutine return address. A later call overwrites that saved value.
- R7: pc_op 5 (return) loads prog_addr with the saved subroutine return address.
- R8: With pc_we and irq_take both high, prog_addr loads the vector 0xFF0 and the current prog_addr is saved as the interrupt return address. This overrides every pc_op, and the subroutine return address is left unchanged.
- R9: pc_op 6 (interrupt return) loads prog_addr with the saved interrupt return address.
- R10: On a cycle with da_we low, data_addr keeps its value whatever da_sel, addr_field, reg_bus and base_ptr carry.
- R11: With da_we high and da_sel 0, data_addr loads addr_field.
- R12: With da_we high and da_sel 1, data_addr loads (base_ptr*16 + reg_bus) mod 4096. For example, base 0xFF with index 0xFF gives 0x0EF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pc_we | input | 1 | Program counter update enable |
| pc_op | input | 3 | PC operation code (0 step, 1 jump, 2 jump if flag, 3 jump if not flag, 4 call, 5 return, 6 interrupt return, 7 step) |
| irq_take | input | 1 | Take the interrupt vector on this update |
| flag | input | 1 | Condition flag for the conditional jumps |
| addr_field | input | 12 | Address field of the current instruction |
| reg_bus | input | 8 | Selected register value, used as the index |
| base_ptr | input | 8 | Base pointer byte |
| da_we | input | 1 | Data address update enable |
| da_sel | input | 1 | Data address source: 0 direct field, 1 indexed |
| prog_addr | output | 12 | Program address |
| data_addr | output | 12 | Data address |

## Verification
A fault in the PC selection shows up on prog_addr at the edge right after the faulty operation, because no other register sits between the two. A corrupted saved return address stays hidden until the next return or interrupt return reads it. For that reason the bench makes two calls in a row and then returns, and it takes an interrupt between a call and its return. An indexing fault shows on data_addr one edge after the load. The carry into the upper nibble is only exercised by large base and index values, so the bench drives both at 0xFF.

// File: rtl/agu_pkg.sv
package agu_pkg;
  typedef enum logic [2:0] {
    OP_STEP = 3'd0,
    OP_JMP  = 3'd1,
    OP_JT   = 3'd2,
    OP_JF   = 3'd3,
    OP_CALL = 3'd4,
    OP_RET  = 3'd5,
    OP_IRET = 3'd6,
    OP_RSVD = 3'd7
  } pc_op_t;
endpackage

// File: rtl/agu_pc_seq.sv
module agu_pc_seq
  import agu_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-1:0] RST_VEC = '0,
  parameter logic [AW-1:0] IRQ_VEC = 12'hFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_we,
  input  logic          irq_take,
  input  pc_op_t        op,
  input  logic          flag,
  input  logic [AW-1:0] addr_field,
  output logic [AW-1:0] pc_q
);
  logic [AW-1:0] lnk_q, ilnk_q, pc_d;

  function automatic logic [AW-1:0] seq_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  // Named events for the checks below
  logic irq_event, ret_event, iret_event, cond_ok, jump_event, call_event, step_event;
  assign irq_event  = pc_we & irq_take;
  assign ret_event  = pc_we & ~irq_take & (op == OP_RET);
  assign iret_event = pc_we & ~irq_take & (op == OP_IRET);
  assign cond_ok    = ((op == OP_JT) & flag) | ((op == OP_JF) & ~flag);
  assign jump_event = pc_we & ~irq_take & ((op == OP_JMP) | (op == OP_CALL) | cond_ok);
  assign call_event = pc_we & ~irq_take & (op == OP_CALL);
  assign step_event = pc_we & ~irq_take & ~ret_event & ~iret_event & ~jump_event;

  always_comb begin
    if (irq_take)                       pc_d = IRQ_VEC;
    else if (op == OP_RET)              pc_d = lnk_q;
    else if (op == OP_IRET)             pc_d = ilnk_q;
    else if ((op == OP_JMP) || (op == OP_CALL) || cond_ok) pc_d = addr_field;
    else                                pc_d = seq_next(pc_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q   <= RST_VEC;
      lnk_q  <= '0;
      ilnk_q <= '0;
    end else begin
      if (pc_we)      pc_q   <= pc_d;
      if (call_event) lnk_q  <= seq_next(pc_q);
      if (irq_event)  ilnk_q <= pc_q;
    end
  end

  // R2
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> $stable(pc_q));
  // R2
  link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_we |=> ($stable(lnk_q) && $stable(ilnk_q)));
  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_event |=> pc_q == AW'($past(pc_q) + AW'(1)));
  // R5
  jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jump_event |=> pc_q == $past(addr_field));
  // R7
  ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ret_event |=> pc_q == $past(lnk_q));
  // R8
  irq_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_event |=> (pc_q == IRQ_VEC && ilnk_q == $past(pc_q) && $stable(lnk_q)));
  // R9
  iret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iret_event |=> pc_q == $past(ilnk_q));
endmodule

// File: rtl/agu_data_addr.sv
module agu_data_addr #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          da_we,
  input  logic          da_sel,
  input  logic [AW-1:0] addr_field,
  input  logic [DW-1:0] reg_bus,
  input  logic [DW-1:0] base_ptr,
  output logic [AW-1:0] da_q
);
  localparam int SH = AW - DW;

  function automatic logic [AW-1:0] idx_ea(input logic [DW-1:0] b, input logic [DW-1:0] r);
    return {b, {SH{1'b0}}} + AW'(r);
  endfunction

  logic direct_event, index_event;
  assign direct_event = da_we & ~da_sel;
  assign index_event  = da_we & da_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)     da_q <= '0;
    else if (da_we) da_q <= da_sel ? idx_ea(base_ptr, reg_bus) : addr_field;
  end

  // R10
  da_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !da_we |=> $stable(da_q));
  // R11
  da_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_event |=> da_q == $past(addr_field));
  // R12
  da_index_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    index_event |=> da_q[SH-1:0] == $past(reg_bus[SH-1:0]));
endmodule

// File: rtl/agu_top.sv
module agu_top
  import agu_pkg::*;
#(
  parameter int AW = 12,
  parameter int DW = 8,
  parameter logic [AW-1:0] RST_VEC = '0,
  parameter logic [AW-1:0] IRQ_VEC = 12'hFF0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pc_we,
  input  logic [2:0]    pc_op,
  input  logic          irq_take,
  input  logic          flag,
  input  logic [AW-1:0] addr_field,
  input  logic [DW-1:0] reg_bus,
  input  logic [DW-1:0] base_ptr,
  input  logic          da_we,
  input  logic          da_sel,
  output logic [AW-1:0] prog_addr,
  output logic [AW-1:0] data_addr
);
  pc_op_t op_dec;
  assign op_dec = pc_op_t'(pc_op);

  agu_pc_seq #(.AW(AW), .RST_VEC(RST_VEC), .IRQ_VEC(IRQ_VEC)) u_pc (
    .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .irq_take(irq_take),
    .op(op_dec), .flag(flag), .addr_field(addr_field), .pc_q(prog_addr)
  );

  agu_data_addr #(.AW(AW), .DW(DW)) u_da (
    .clk(clk), .rst_n(rst_n), .da_we(da_we), .da_sel(da_sel),
    .addr_field(addr_field), .reg_bus(reg_bus), .base_ptr(base_ptr),
    .da_q(data_addr)
  );

  // R1
  reset_val_chk: assert property (@(posedge clk)
    !rst_n |=> (prog_addr == RST_VEC && data_addr == '0));
endmodule

// File: tb/agu_top_test.sv
`timescale 1ns/1ps
module agu_top_test;
  logic clk = 0, rst_n = 0;
  logic pc_we = 0, irq_take = 0, flag = 0, da_we = 0, da_sel = 0;
  logic [2:0] pc_op = 0;
  logic [11:0] addr_field = 0;
  logic [7:0] reg_bus = 0, base_ptr = 0;
  logic [11:0] prog_addr, data_addr;

  int checks = 0, errors = 0;
  bit finished = 0;
  int q_pc[$], q_da[$];
  string q_tag[$];
  int m_pc = 0, m_da = 0, m_lnk = 0, m_ilnk = 0;

  always #2.5 clk = ~clk;

  agu_top uut (
    .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_op(pc_op), .irq_take(irq_take),
    .flag(flag), .addr_field(addr_field), .reg_bus(reg_bus), .base_ptr(base_ptr),
    .da_we(da_we), .da_sel(da_sel), .prog_addr(prog_addr), .data_addr(data_addr)
  );

  task automatic drv(input bit we, input int op, input bit irq, input int addr,
                     input bit f, input bit dwe, input bit dsel, input int rb,
                     input int bp, input string tag);
    int npc;
    pc_we = we; pc_op = 3'(op); irq_take = irq; addr_field = 12'(addr);
    flag = f; da_we = dwe; da_sel = dsel; reg_bus = 8'(rb); base_ptr = 8'(bp);
    npc = m_pc;
    if (we) begin
      if (irq) begin m_ilnk = m_pc; npc = 'hFF0; end
      else case (op)
        1: npc = addr;
        2: npc = f ? addr : (m_pc + 1) % 4096;
        3: npc = !f ? addr : (m_pc + 1) % 4096;
        4: begin m_lnk = (m_pc + 1) % 4096; npc = addr; end
        5: npc = m_lnk;
        6: npc = m_ilnk;
        default: npc = (m_pc + 1) % 4096;
      endcase
    end
    m_pc = npc;
    if (dwe) m_da = dsel ? (bp * 16 + rb) % 4096 : addr;
    q_pc.push_back(m_pc); q_da.push_back(m_da); q_tag.push_back(tag);
    @(negedge clk);
  endtask

  // Monitor: compare each produced result against the scoreboard head
  initial forever begin
    @(posedge clk); #1;
    if (q_pc.size() > 0) begin
      int ep, ed; string t;
      ep = q_pc.pop_front(); ed = q_da.pop_front(); t = q_tag.pop_front();
      checks++;
      if (int'(prog_addr) != ep || int'(data_addr) != ed) begin
        errors++;
        $display("FAIL %s pc=%h/%h da=%h/%h (actual/expected)", t, prog_addr, ep, data_addr, ed);
      end
    end
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    pc_op = 3'd4; addr_field = 12'h555; pc_we = 1; da_we = 1; da_sel = 1; reg_bus = 8'h77;
    repeat (3) @(negedge clk);
    checks++;
    if (prog_addr !== 12'h000 || data_addr !== 12'h000) begin
      errors++;
      $display("FAIL R1 pc=%h da=%h expected 000/000", prog_addr, data_addr);
    end
    rst_n = 1;
    // R1: saved addresses are zero after reset
    drv(1, 5, 0, 'h321, 0, 0, 0, 0, 0, "R1");
    drv(1, 6, 0, 'h321, 0, 0, 0, 0, 0, "R1");
    // R3 step and reserved code
    drv(1, 0, 0, 'h888, 1, 0, 0, 0, 0, "R3");
    drv(1, 7, 0, 'h888, 1, 0, 0, 0, 0, "R3");
    // R11 direct data load
    drv(1, 0, 0, 'h9A5, 0, 1, 0, 'h12, 'h34, "R11");
    // R2 and R10 hold with busy inputs
    drv(0, 1, 1, 'hABC, 1, 0, 1, 'hFF, 'hFF, "R2");
    drv(0, 4, 0, 'h111, 0, 0, 0, 'h01, 'h02, "R10");
    // R4 jump, R3 wrap
    drv(1, 1, 0, 'hFFF, 0, 0, 0, 0, 0, "R4");
    drv(1, 0, 0, 'h000, 0, 0, 0, 0, 0, "R3");
    // R5 conditional jumps both ways
    drv(1, 2, 0, 'h123, 0, 0, 0, 0, 0, "R5");
    drv(1, 2, 0, 'h123, 1, 0, 0, 0, 0, "R5");
    drv(1, 3, 0, 'h200, 1, 0, 0, 0, 0, "R5");
    drv(1, 3, 0, 'h200, 0, 0, 0, 0, 0, "R5");
    // R6 two calls, R7 returns to the second
    drv(1, 4, 0, 'h400, 0, 0, 0, 0, 0, "R6");
    drv(1, 4, 0, 'h500, 0, 0, 0, 0, 0, "R6");
    drv(1, 5, 0, 'h777, 0, 0, 0, 0, 0, "R7");
    // R6 link wrap from 0xFFF
    drv(1, 1, 0, 'hFFF, 0, 0, 0, 0, 0, "R4");
    drv(1, 4, 0, 'h010, 0, 0, 0, 0, 0, "R6");
    drv(1, 0, 0, 'h000, 0, 0, 0, 0, 0, "R3");
    // R8 interrupt overrides a call, R9 interrupt return
    drv(1, 4, 1, 'h333, 1, 0, 0, 0, 0, "R8");
    drv(1, 0, 0, 'h000, 0, 0, 0, 0, 0, "R3");
    drv(1, 5, 0, 'h000, 0, 0, 0, 0, 0, "R8");
    drv(1, 1, 0, 'h0AA, 0, 0, 0, 0, 0, "R4");
    drv(1, 6, 0, 'h000, 0, 0, 0, 0, 0, "R9");
    drv(1, 5, 1, 'h000, 0, 0, 0, 0, 0, "R8");
    drv(1, 6, 0, 'h000, 0, 0, 0, 0, 0, "R9");
    // R12 indexed data addresses
    drv(0, 0, 0, 'hFFF, 0, 1, 1, 'h34, 'h12, "R12");
    drv(0, 0, 0, 'hFFF, 0, 1, 1, 'hFF, 'hFF, "R12");
    drv(0, 0, 0, 'hFFF, 0, 1, 1, 'h0F, 'h01, "R12");
    drv(0, 0, 0, 'h000, 0, 1, 1, 'h00, 'h80, "R12");
    drv(0, 0, 0, 'h5A5, 0, 0, 1, 'h11, 'h22, "R10");
    drv(1, 0, 0, 'h5A5, 0, 1, 0, 'h11, 'h22, "R11");
    pc_we = 0; da_we = 0;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule